// File: doc/BRIEF.md
# Sparse-Window Bus Address Translator

This block sits between a processor's load/store path and a 32-bit peripheral bus. A processor access lands in one of two sparse windows: an I/O window or a memory window. In a sparse window every bus byte address occupies a 32-byte slot of processor address. The block takes the bus address, the byte lane and the transfer size out of the processor address. It then drives a single bus cycle with byte enables and data steered to the correct lanes. For reads it returns the selected bytes zero-extended to bit 0.

The memory window carries only the low 27 bus address bits. The five bits above them come from an extension register, which software writes through a separate register port. That register keeps its value until software writes it again. The I/O window carries 24 bus address bits and never uses the extension register. Any access outside both windows, with a reserved size code, or with a misaligned lane ends in a one-cycle fault pulse, and no bus cycle is issued.

Control is a four-state machine:
- IDLE: accepts a request.
- BUS: holds the bus request until it is acknowledged.
- DONE: pulses the response.
- FAULT: pulses the error.

The transitions are:
- IDLE to BUS: a good request is accepted.
- IDLE to FAULT: a rejected request is accepted.
- BUS to BUS: no acknowledge yet.
- BUS to DONE: acknowledge.
- DONE to IDLE and FAULT to IDLE: unconditional.

Top module: `sparse_xlate`

## Requirements
- R1: The I/O window is the 2^29-byte region starting at processor address 0x1_C000_0000. The memory window is the 2^32-byte region starting at 0x2_0000_0000. A request in neither window raises `rsp_err` for one cycle and issues no bus cycle.
- R2: Processor address bits 4:3 encode the size: 00 = byte, 01 = halfword, 11 = longword. Code 10 is rejected as a fault. Processor address bits 2:0 must be zero, otherwise the request is a fault.
- R3: The bus address is the window offset shifted right by five. In the memory window, bus address bits 26:0 come from processor bits 31:5 and bits 31:27 come from the extension register. In the I/O window, bus bits 23:0 come from processor bits 28:5, bits 31:24 are zero, and `bus_io` is 1.
- R4: The byte lane is bus address bits 1:0. `bus_be` is `0001<<lane` for a byte, `0011<<lane` for a halfword, and `1111` for a longword.
- R5: For a write, `bus_wdata` is `req_wdata` shifted left by 8×lane, truncated to 32 bits, and `bus_write` is 1.
- R6: A halfword at lane 3, or a longword at any lane other than 0, raises `rsp_err` for one cycle and issues no bus cycle.
- R7: `rsp_valid` pulses for exactly one cycle, in the cycle after the edge at which `bus_ack` is sampled. For a read, `rsp_rdata` is `bus_rdata` shifted right by 8×lane, masked to 8, 16 or 32 bits by size. For a write it is zero.
- R8: When `ext_wr` is asserted, the extension register loads `ext_wdata` at that edge. Otherwise it holds its value. `ext_rdata` shows it. A new value changes the memory-window bus address of later requests and leaves I/O-window addresses unchanged.
- R9: `req_ready` is 1 only in IDLE. While `bus_valid` is 1 and `bus_ack` is 0, the bus address, enables and data stay stable and `bus_valid` stays 1.
- R10: After reset the block is in IDLE: `req_ready`=1, `bus_valid`=0, `rsp_valid`=0, `rsp_err`=0, and the extension register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 34 | Processor sparse address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Completion pulse |
| rsp_err | output | 1 | Fault pulse (request rejected) |
| rsp_rdata | output | 32 | Read data, zero-extended from bit 0 |
| ext_wr | input | 1 | Extension register write strobe |
| ext_wdata | input | 5 | Extension register write value |
| ext_rdata | output | 5 | Extension register contents |
| bus_valid | output | 1 | Bus cycle request |
| bus_ack | input | 1 | Bus cycle completes |
| bus_addr | output | 32 | Bus byte address |
| bus_io | output | 1 | 1 = I/O space, 0 = memory space |
| bus_write | output | 1 | Bus write |
| bus_be | output | 4 | Byte enables |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_rdata | input | 32 | Bus read data, lane-aligned |

## Verification
Directed cases cover each window edge, addresses outside both windows, every size code including the reserved one, and the misaligned lane pairs. They also cover extension register values of 0 and all ones, which show whether the upper address bits come from the register in the memory window only. Random requests spread over both windows and an outside region, with random lanes, sizes, data and acknowledge delays. These show whether lane steering in both directions matches size and lane, and whether the request holds still across stalls of different lengths. Random rewrites of the extension register between requests show whether a stale or leaked register value reaches the bus address.

// File: rtl/sxl_pkg.sv
package sxl_pkg;

    localparam int BUS_AW     = 32;
    localparam int DATA_W     = 32;
    localparam int LANES      = DATA_W / 8;
    localparam int LANE_W     = $clog2(LANES);
    localparam int SLOT_SHIFT = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_RSVD = 2'b10,
        SZ_WORD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUS   = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } state_e;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic              io;
        logic              write;
        logic [LANE_W-1:0] lane;
        size_e             size;
    } bus_cmd_t;

    function automatic logic [DATA_W-1:0] lane_extract(
        input logic [DATA_W-1:0] word,
        input logic [LANE_W-1:0] lane,
        input size_e             size
    );
        logic [DATA_W-1:0] shifted;
        shifted = word >> {lane, 3'b000};
        unique case (size)
            SZ_BYTE: lane_extract = {{(DATA_W-8){1'b0}},  shifted[7:0]};
            SZ_HALF: lane_extract = {{(DATA_W-16){1'b0}}, shifted[15:0]};
            default: lane_extract = shifted;
        endcase
    endfunction

endpackage

// File: rtl/sxl_ext_reg.sv
module sxl_ext_reg #(
    parameter int EXT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [EXT_W-1:0] wdata,
    output logic [EXT_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata;
    end

    assert_ext_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));
    assert_ext_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q == $past(wdata)));

endmodule

// File: rtl/sxl_decode.sv
module sxl_decode
    import sxl_pkg::*;
#(
    parameter int              PA_W         = 34,
    parameter int              IO_WIN_BITS  = 24,
    parameter int              MEM_WIN_BITS = 27,
    parameter logic [PA_W-1:0] IO_BASE      = 34'h1_C000_0000,
    parameter logic [PA_W-1:0] MEM_BASE     = 34'h2_0000_0000,
    localparam int             EXT_W        = BUS_AW - MEM_WIN_BITS
) (
    input  logic [PA_W-1:0]   addr,
    input  logic              write,
    input  logic [DATA_W-1:0] wdata,
    input  logic [EXT_W-1:0]  ext,
    output bus_cmd_t          cmd,
    output logic              fault
);

    localparam int IO_SPAN  = IO_WIN_BITS + SLOT_SHIFT;
    localparam int MEM_SPAN = MEM_WIN_BITS + SLOT_SHIFT;

    logic              in_io, in_mem, hit, low_dirty, misalign;
    logic [LANE_W-1:0] lane;
    size_e             size;
    logic [LANES-1:0]  be;

    assign in_io     = (addr[PA_W-1:IO_SPAN]  == IO_BASE[PA_W-1:IO_SPAN]);
    assign in_mem    = (addr[PA_W-1:MEM_SPAN] == MEM_BASE[PA_W-1:MEM_SPAN]);
    assign hit       = in_io | in_mem;
    assign size      = size_e'(addr[4:3]);
    assign lane      = addr[SLOT_SHIFT+LANE_W-1:SLOT_SHIFT];
    assign low_dirty = |addr[2:0];

    always_comb begin
        unique case (size)
            SZ_HALF: misalign = (lane == LANE_W'(LANES-1));
            SZ_WORD: misalign = (lane != '0);
            default: misalign = 1'b0;
        endcase
    end

    assign fault = !hit || low_dirty || misalign || (size == SZ_RSVD);

    for (genvar i = 0; i < LANES; i++) begin : g_be
        logic at, next;
        assign at   = (lane == LANE_W'(i));
        assign next = (LANE_W'(lane + LANE_W'(1)) == LANE_W'(i));
        assign be[i] = (size == SZ_WORD) ||
                       ((size == SZ_BYTE) && at) ||
                       ((size == SZ_HALF) && (at || next));
    end

    always_comb begin
        cmd       = '0;
        cmd.io    = in_io;
        cmd.write = write;
        cmd.lane  = lane;
        cmd.size  = size;
        cmd.be    = be;
        cmd.wdata = wdata << {lane, 3'b000};
        if (in_io)
            cmd.addr = {{(BUS_AW-IO_WIN_BITS){1'b0}}, addr[IO_SPAN-1:SLOT_SHIFT]};
        else
            cmd.addr = {ext, addr[MEM_SPAN-1:SLOT_SHIFT]};
    end

endmodule

// File: rtl/sxl_bus_seq.sv
module sxl_bus_seq
    import sxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  bus_cmd_t          dec_cmd,
    input  logic              dec_fault,
    output logic              bus_valid,
    input  logic              bus_ack,
    output bus_cmd_t          bus_cmd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    state_e   state, state_nx;
    bus_cmd_t cmd_q;
    logic     accept;

    assign accept = (state == ST_IDLE) && req_valid;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = dec_fault ? ST_FAULT : ST_BUS;
            ST_BUS:   if (bus_ack)   state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            rsp_rdata <= '0;
        end else begin
            if (accept && !dec_fault) cmd_q <= dec_cmd;
            if ((state == ST_BUS) && bus_ack)
                rsp_rdata <= cmd_q.write ? '0
                                         : lane_extract(bus_rdata, cmd_q.lane, cmd_q.size);
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        bus_valid = (state == ST_BUS);
        rsp_valid = (state == ST_DONE);
        rsp_err   = (state == ST_FAULT);
        bus_cmd   = cmd_q;
    end

    assert_fault_no_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && dec_fault) |=> (rsp_err && !bus_valid));
    assert_rsp_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ack) |=> (rsp_valid && !bus_valid));
    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_cmd.addr)
                                      && $stable(bus_cmd.be) && $stable(bus_cmd.wdata)));
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);
    assert_be_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ($countones(bus_cmd.be) == 1 || $countones(bus_cmd.be) == 2
                       || $countones(bus_cmd.be) == LANES));
    assert_io_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd.io) |-> (bus_cmd.addr[BUS_AW-1:24] == '0));

endmodule

// File: rtl/sparse_xlate.sv
module sparse_xlate
    import sxl_pkg::*;
#(
    parameter int              PA_W         = 34,
    parameter int              IO_WIN_BITS  = 24,
    parameter int              MEM_WIN_BITS = 27,
    parameter logic [PA_W-1:0] IO_BASE      = 34'h1_C000_0000,
    parameter logic [PA_W-1:0] MEM_BASE     = 34'h2_0000_0000,
    localparam int             EXT_W        = BUS_AW - MEM_WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PA_W-1:0]   req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              ext_wr,
    input  logic [EXT_W-1:0]  ext_wdata,
    output logic [EXT_W-1:0]  ext_rdata,
    output logic              bus_valid,
    input  logic              bus_ack,
    output logic [BUS_AW-1:0] bus_addr,
    output logic              bus_io,
    output logic              bus_write,
    output logic [LANES-1:0]  bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    bus_cmd_t dec_cmd, bus_cmd;
    logic     dec_fault;

    sxl_ext_reg #(.EXT_W(EXT_W)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ext_wr),
        .wdata (ext_wdata),
        .q     (ext_rdata)
    );

    sxl_decode #(
        .PA_W         (PA_W),
        .IO_WIN_BITS  (IO_WIN_BITS),
        .MEM_WIN_BITS (MEM_WIN_BITS),
        .IO_BASE      (IO_BASE),
        .MEM_BASE     (MEM_BASE)
    ) u_dec (
        .addr  (req_addr),
        .write (req_write),
        .wdata (req_wdata),
        .ext   (ext_rdata),
        .cmd   (dec_cmd),
        .fault (dec_fault)
    );

    sxl_bus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .dec_cmd   (dec_cmd),
        .dec_fault (dec_fault),
        .bus_valid (bus_valid),
        .bus_ack   (bus_ack),
        .bus_cmd   (bus_cmd),
        .bus_rdata (bus_rdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    assign bus_addr  = bus_cmd.addr;
    assign bus_io    = bus_cmd.io;
    assign bus_write = bus_cmd.write;
    assign bus_be    = bus_cmd.be;
    assign bus_wdata = bus_cmd.wdata;

endmodule

// File: tb/sparse_xlate_tb.sv
module sparse_xlate_tb;

    localparam logic [33:0] IO_B  = 34'h1_C000_0000;
    localparam logic [33:0] MEM_B = 34'h2_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [33:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, req_ready;
    logic [31:0] rsp_rdata;
    logic        ext_wr = 1'b0;
    logic [4:0]  ext_wdata = '0, ext_rdata;
    logic        bus_valid, bus_io, bus_write;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic [3:0]  bus_be;

    int errors = 0, checks = 0;
    bit finished = 0;
    logic [4:0] ext_model = '0;
    int seed_sink;

    always #5 clk = ~clk;

    sparse_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ext_wr(ext_wr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .bus_valid(bus_valid), .bus_ack(bus_ack), .bus_addr(bus_addr),
        .bus_io(bus_io), .bus_write(bus_write), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct {
        bit          fault;
        logic [31:0] addr;
        bit          io;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] rdata;
    } exp_t;

    function automatic exp_t model(input logic [33:0] a, input logic wr,
                                   input logic [31:0] wd, input logic [31:0] rd,
                                   input logic [4:0] ext);
        exp_t e;
        logic [63:0] off;
        int sz, ln;
        bit io, mem;
        e = '{default: 0};
        io  = (a >= IO_B)  && (a < IO_B + 34'h2000_0000);
        mem = (a >= MEM_B) && ({30'd0, a} < {30'd0, MEM_B} + 64'h1_0000_0000);
        off = io ? {30'd0, a - IO_B} : {30'd0, a - MEM_B};
        sz  = int'((off >> 3) & 3);
        ln  = int'((off >> 5) & 3);
        e.fault = !(io || mem) || ((off & 7) != 0) || sz == 2 ||
                  (sz == 1 && ln == 3) || (sz == 3 && ln != 0);
        e.io = io;
        if (io) e.addr = 32'(off >> 5);
        else    e.addr = 32'((off >> 5) | ({59'd0, ext} << 27));
        case (sz)
            0: e.be = 4'(1 << ln);
            1: e.be = 4'(3 << ln);
            default: e.be = 4'hF;
        endcase
        e.wdata = 32'({32'd0, wd} << (8 * ln));
        if (wr) e.rdata = 0;
        else begin
            e.rdata = rd >> (8 * ln);
            if (sz == 0) e.rdata = e.rdata & 32'hFF;
            else if (sz == 1) e.rdata = e.rdata & 32'hFFFF;
        end
        return e;
    endfunction

    task automatic write_ext(input logic [4:0] v);
        @(negedge clk);
        ext_wr = 1'b1; ext_wdata = v;
        @(negedge clk);
        ext_wr = 1'b0;
        ext_model = v;
        check(ext_rdata == v, "R8 extension readback", {59'd0, ext_rdata}, {59'd0, v});
    endtask

    task automatic do_req(input logic [33:0] a, input logic wr, input logic [31:0] wd,
                          input int dly, input logic [31:0] rd, input string tag);
        exp_t e;
        logic [31:0] held;
        e = model(a, wr, wd, rd, ext_model);
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready in idle", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (e.fault) begin
            check(rsp_err && !bus_valid, {tag, " fault pulse, no bus cycle"},
                  {62'd0, rsp_err, bus_valid}, 64'h2);
            @(negedge clk);
            check(!rsp_err && req_ready, {tag, " fault pulse one cycle"},
                  {62'd0, rsp_err, req_ready}, 64'h1);
        end else begin
            check(bus_valid, {tag, " R9 bus request"}, {63'd0, bus_valid}, 64'd1);
            check(bus_addr == e.addr && bus_io == e.io, {tag, " R3 address"},
                  {31'd0, bus_io, bus_addr}, {31'd0, e.io, e.addr});
            check(bus_be == e.be, {tag, " R4 enables"}, {60'd0, bus_be}, {60'd0, e.be});
            check(bus_write == wr, {tag, " R5 direction"}, {63'd0, bus_write}, {63'd0, wr});
            if (wr) check(bus_wdata == e.wdata, {tag, " R5 write data"},
                          {32'd0, bus_wdata}, {32'd0, e.wdata});
            held = bus_addr;
            for (int k = 0; k < dly; k++) begin
                @(negedge clk);
                check(bus_valid && bus_addr == held && !req_ready, {tag, " R9 hold while stalled"},
                      {31'd0, bus_valid, bus_addr}, {31'd1, held});
            end
            bus_ack = 1'b1; bus_rdata = rd;
            @(negedge clk);
            bus_ack = 1'b0;
            check(rsp_valid && !bus_valid, {tag, " R7 response after ack"},
                  {62'd0, rsp_valid, bus_valid}, 64'h2);
            check(rsp_rdata == e.rdata, {tag, " R7 read data"},
                  {32'd0, rsp_rdata}, {32'd0, e.rdata});
            @(negedge clk);
            check(!rsp_valid && req_ready, {tag, " R7 one-cycle pulse"},
                  {62'd0, rsp_valid, req_ready}, 64'h1);
        end
    endtask

    function automatic logic [33:0] mk(input logic [33:0] base, input logic [31:0] busa,
                                       input logic [1:0] sz);
        return base + ({2'd0, busa} << 5) + ({32'd0, sz} << 3);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        seed_sink = $urandom(32'h5A17);
        repeat (3) @(negedge clk);
        // R10 reset state
        check(req_ready && !bus_valid && !rsp_valid && !rsp_err && ext_rdata == 0,
              "R10 reset state", {59'd0, req_ready, bus_valid, rsp_valid, rsp_err, ext_rdata == 0},
              64'h11);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        do_req(mk(IO_B, 32'h00_1234, 2'b00), 1'b0, 0, 0, 32'hA1B2C3D4, "R3 io byte lane0");
        do_req(mk(IO_B, 32'h00_FFFF, 2'b00), 1'b0, 0, 1, 32'hA1B2C3D4, "R4 io byte lane3");
        do_req(mk(IO_B, 32'hFF_FFFE, 2'b01), 1'b1, 32'h0000BEEF, 2, 0, "R5 io half lane2 last slot");
        do_req(mk(IO_B, 32'h00_0001, 2'b01), 1'b0, 0, 0, 32'h11223344, "R4 io half lane1");
        write_ext(5'h1F);
        do_req(mk(MEM_B, 32'h07FF_FFFC, 2'b11), 1'b1, 32'hCAFEF00D, 3, 0, "R3 mem word ext all ones");
        do_req(mk(IO_B, 32'h00_0100, 2'b11), 1'b0, 0, 0, 32'h89ABCDEF, "R8 io ignores ext");
        write_ext(5'h00);
        do_req(mk(MEM_B, 32'h0000_0003, 2'b00), 1'b0, 0, 0, 32'h80FF_FF7F, "R8 mem ext zero");
        do_req(mk(MEM_B, 32'h0000_0003, 2'b01), 1'b0, 0, 0, 0, "R6 half lane3");
        do_req(mk(MEM_B, 32'h0000_0002, 2'b11), 1'b1, 1, 0, 0, "R6 word lane2");
        do_req(mk(IO_B, 32'h0000_0000, 2'b10), 1'b0, 0, 0, 0, "R2 reserved size");
        do_req(mk(IO_B, 32'h0000_0000, 2'b00) + 34'd4, 1'b0, 0, 0, 0, "R2 low bits set");
        do_req(IO_B - 34'd32, 1'b0, 0, 0, 0, "R1 below io window");
        do_req(34'h1_E000_0000, 1'b0, 0, 0, 0, "R1 above io window");
        do_req(34'h0_0000_0000, 1'b1, 0, 0, 0, "R1 low outside");

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [33:0] a;
            logic [31:0] busa;
            int w;
            if ($urandom_range(0, 9) == 0) write_ext(5'($urandom));
            busa = $urandom;
            w = $urandom_range(0, 9);
            if (w < 4)      a = mk(IO_B, busa & 32'h00FF_FFFF, 2'($urandom));
            else if (w < 9) a = mk(MEM_B, busa & 32'h07FF_FFFF, 2'($urandom));
            else            a = 34'h1_2000_0000 + 34'($urandom & 32'h0FFF_FFE0);
            do_req(a, 1'($urandom), $urandom, $urandom_range(0, 3), $urandom, "R1 R2 R4 R5 R7 random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule